// File: doc/BRIEF.md
# Voice Key Control Register Front End

This block sits between a host and an eight-voice sound generator. The host reaches 128 byte-wide registers indirectly: a write on the index strobe selects a register, and a later write on the data strobe stores a byte there. Most registers are plain storage for the rest of the generator. Four global control registers and the noise-enable register are decoded inside the block.

A key-on write starts voices at once when their key-off bit is clear. When the key-off bit is set, the key-on is held back and carried out by the next key-off write that clears that bit. A key-off write releases voices that are sounding. The block keeps a keyed flag and a pending flag for each voice. It drives one-cycle start and release pulses, one per voice, and a per-voice noise-source select. End-of-sample flags are set by the sample engine through `voice_done`. A key-on clears the voice's end flag, and a host write to the end register clears all of them. Writing the flags register with bit 7 set performs a soft reset.

Top module: `voice_key_regs`

## Requirements
- R1: After synchronous reset, the flags register (index 0x6C) reads 0x60, which is bit 6 mute plus bit 5 echo-off. The key-on (0x4C), key-off (0x5C), end (0x7C) and all other registers read 0x00. The start, release and noise outputs are 0.
- R2: `rdata` always shows the register chosen by bits [6:0] of the last index write. A data write to any undecoded index stores the byte as written.
- R3: Take a key-on write in which bit i is set and key-off bit i is clear. Voice i gets a start pulse in the cycle after the write, becomes keyed, and has end bit i cleared.
- R4: Take a key-on write in which bit i is set and key-off bit i is set. Voice i gets no start pulse and becomes pending.
- R5: A key-off write with bit i set releases voice i only if it is keyed. The release pulse comes in the cycle after the write, the voice leaves the keyed state, its pending flag is cleared, and key-on register bit i is cleared. A set bit for a voice that is not keyed produces no pulse.
- R6: A key-off write with bit i clear starts a pending voice i. The start pulse comes in the next cycle, the voice becomes keyed and no longer pending, and end bit i is cleared.
- R7: A host write to the end register stores 0x00 whatever the data. A `voice_done` bit seen in any cycle sets the matching end bit, and wins over a clear in that same cycle.
- R8: A flags write with bit 7 set stores 0x60 OR the low 5 data bits. It clears the key-on, key-off and end registers and every keyed and pending flag, with no pulse.
- R9: A flags write with bit 7 clear stores the byte unchanged. Its low 5 bits are the noise clock rate.
- R10: `noise_sel[i]` equals bit i of the noise-enable register (index 0x3D). 1 selects the noise source.
- R11: The key-on and key-off registers read back the last byte written to them, apart from the key-on bits cleared by releases (R5).
- R12: Start and release pulses last one cycle. A voice never gets both in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| idx_we | input | 1 | Load the register index from `wdata` |
| data_we | input | 1 | Write `wdata` to the indexed register (ignored while `idx_we` is high) |
| wdata | input | 8 | Host write byte |
| voice_done | input | 8 | Per-voice end-of-sample events from the sample engine |
| rdata | output | 8 | Contents of the indexed register |
| voice_start | output | 8 | One-cycle start pulse per voice |
| voice_release | output | 8 | One-cycle release pulse per voice |
| noise_sel | output | 8 | Per-voice noise source select |

## Verification
The assertions take the host to use one strobe at a time. The index-priority rule is the only case that covers both strobes at once, and no property depends on it. They also take `voice_done` to be a plain level sampled each clock, with no relation to the host strobes. The stimulus never raises both strobes together. It drives `voice_done` only as short bursts, either between host writes or on the same cycle as a write, so that the rule for a set winning over a clear is exercised. Directed sequences arrange the held key-off cases before key-on writes, and random traffic is weighted toward the decoded indexes.

// File: rtl/voice_key_pkg.sv
package voice_key_pkg;

    localparam int NVOICE = 8;
    localparam int DW     = 8;
    localparam int AW     = 7;
    localparam int NREG   = 1 << AW;

    localparam logic [AW-1:0] ADDR_KEYON  = 7'h4C;
    localparam logic [AW-1:0] ADDR_KEYOFF = 7'h5C;
    localparam logic [AW-1:0] ADDR_FLAGS  = 7'h6C;
    localparam logic [AW-1:0] ADDR_END    = 7'h7C;
    localparam logic [AW-1:0] ADDR_NOISE  = 7'h3D;

    localparam logic [DW-1:0] FLAG_MUTE     = 8'h40;
    localparam logic [DW-1:0] FLAG_ECHO_OFF = 8'h20;
    localparam logic [DW-1:0] RATE_MASK     = 8'h1F;
    localparam int            SOFT_RST_BIT  = 7;

    typedef enum logic [2:0] {
        WK_NONE,
        WK_KEYON,
        WK_KEYOFF,
        WK_FLAGS,
        WK_END,
        WK_OTHER
    } wr_kind_t;

    typedef struct packed {
        logic [DW-1:0] keyon;
        logic [DW-1:0] keyoff;
        logic [DW-1:0] endf;
        logic [DW-1:0] flags;
    } glob_regs_t;

    function automatic wr_kind_t classify_write(input logic en, input logic [AW-1:0] a);
        if (!en)                 return WK_NONE;
        else if (a == ADDR_KEYON)  return WK_KEYON;
        else if (a == ADDR_KEYOFF) return WK_KEYOFF;
        else if (a == ADDR_FLAGS)  return WK_FLAGS;
        else if (a == ADDR_END)    return WK_END;
        else                       return WK_OTHER;
    endfunction

    function automatic logic [DW-1:0] flags_after_soft_reset(input logic [DW-1:0] b);
        return FLAG_MUTE | FLAG_ECHO_OFF | (b & RATE_MASK);
    endfunction

    function automatic glob_regs_t glob_reset_value();
        glob_regs_t g;
        g.keyon  = '0;
        g.keyoff = '0;
        g.endf   = '0;
        g.flags  = FLAG_MUTE | FLAG_ECHO_OFF;
        return g;
    endfunction

endpackage

// File: rtl/vk_index_reg.sv
module vk_index_reg #(
    parameter int AW = 7
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          load,
    input  logic [AW-1:0] idx_in,
    output logic [AW-1:0] idx_q
);
    always_ff @(posedge clk) begin
        if (rst)       idx_q <= '0;
        else if (load) idx_q <= idx_in;
    end
endmodule

// File: rtl/vk_regfile.sv
module vk_regfile #(
    parameter int            NREG       = 128,
    parameter int            DW         = 8,
    parameter int            AW         = 7,
    parameter logic [AW-1:0] NOISE_ADDR = 7'h3D
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          we,
    input  logic [AW-1:0] waddr,
    input  logic [DW-1:0] wbyte,
    input  logic [AW-1:0] raddr,
    output logic [DW-1:0] rbyte,
    output logic [DW-1:0] noise_byte
);
    logic [DW-1:0] mem [NREG];

    for (genvar e = 0; e < NREG; e++) begin : g_entry
        always_ff @(posedge clk) begin
            if (rst)
                mem[e] <= '0;
            else if (we && waddr == AW'(e))
                mem[e] <= wbyte;
        end
    end

    assign rbyte      = mem[raddr];
    assign noise_byte = mem[NOISE_ADDR];

    // R10: the noise byte follows a write to its index on the next cycle
    p_noise_follows_r10: assert property (@(posedge clk) disable iff (rst)
        (we && waddr == NOISE_ADDR) |=> (noise_byte == $past(wbyte)));
endmodule

// File: rtl/vk_key_ctrl.sv
module vk_key_ctrl
    import voice_key_pkg::*;
#(
    parameter int NV = NVOICE
) (
    input  logic          clk,
    input  logic          rst,
    input  wr_kind_t      kind,
    input  logic [DW-1:0] wbyte,
    input  logic [NV-1:0] voice_done,
    output glob_regs_t    g_q,
    output logic [NV-1:0] start_q,
    output logic [NV-1:0] rel_q
);
    logic [NV-1:0] keyed_q, pend_q;
    logic [NV-1:0] keyed_n, pend_n, start_n, rel_n;
    glob_regs_t    g_n;

    always_comb begin
        g_n     = g_q;
        keyed_n = keyed_q;
        pend_n  = pend_q;
        start_n = '0;
        rel_n   = '0;
        unique case (kind)
            WK_FLAGS: begin
                if (wbyte[SOFT_RST_BIT]) begin
                    g_n.flags  = flags_after_soft_reset(wbyte);
                    g_n.keyon  = '0;
                    g_n.keyoff = '0;
                    g_n.endf   = '0;
                    keyed_n    = '0;
                    pend_n     = '0;
                end else begin
                    g_n.flags = wbyte;
                end
            end
            WK_END: g_n.endf = '0;
            WK_KEYON: begin
                g_n.keyon = wbyte;
                for (int v = 0; v < NV; v++) begin
                    if (wbyte[v]) begin
                        if (!g_q.keyoff[v]) begin
                            start_n[v]  = 1'b1;
                            keyed_n[v]  = 1'b1;
                            pend_n[v]   = 1'b0;
                            g_n.endf[v] = 1'b0;
                        end else begin
                            pend_n[v] = 1'b1;
                        end
                    end
                end
            end
            WK_KEYOFF: begin
                g_n.keyoff = wbyte;
                for (int v = 0; v < NV; v++) begin
                    if (wbyte[v]) begin
                        if (keyed_q[v]) begin
                            rel_n[v]     = 1'b1;
                            keyed_n[v]   = 1'b0;
                            pend_n[v]    = 1'b0;
                            g_n.keyon[v] = 1'b0;
                        end
                    end else if (pend_q[v]) begin
                        start_n[v]  = 1'b1;
                        keyed_n[v]  = 1'b1;
                        pend_n[v]   = 1'b0;
                        g_n.endf[v] = 1'b0;
                    end
                end
            end
            default: ;
        endcase
        g_n.endf = g_n.endf | voice_done;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            g_q     <= glob_reset_value();
            keyed_q <= '0;
            pend_q  <= '0;
            start_q <= '0;
            rel_q   <= '0;
        end else begin
            g_q     <= g_n;
            keyed_q <= keyed_n;
            pend_q  <= pend_n;
            start_q <= start_n;
            rel_q   <= rel_n;
        end
    end

    // R12: a voice never starts and releases in the same cycle
    p_start_rel_excl_r12: assert property (@(posedge clk) disable iff (rst)
        (start_q & rel_q) == '0);
    // R3: every started voice is keyed
    p_start_keyed_r3: assert property (@(posedge clk) disable iff (rst)
        (start_q & ~keyed_q) == '0);
    // R5: a released voice is no longer keyed
    p_rel_unkeyed_r5: assert property (@(posedge clk) disable iff (rst)
        (rel_q & keyed_q) == '0);
    // R3: a start leaves its end flag clear unless a done event came along
    p_start_end_clr_r3: assert property (@(posedge clk) disable iff (rst)
        (start_q & g_q.endf & ~$past(voice_done)) == '0);
    // R4: a key-on never starts a voice whose key-off bit was held
    p_deferred_r4: assert property (@(posedge clk) disable iff (rst)
        (kind == WK_KEYON) |=> ((start_q & $past(g_q.keyoff)) == '0));
    // R8: soft reset
    p_soft_reset_r8: assert property (@(posedge clk) disable iff (rst)
        (kind == WK_FLAGS && wbyte[SOFT_RST_BIT]) |=>
        (g_q.keyon == '0 && g_q.keyoff == '0 && g_q.flags[6:5] == 2'b11 &&
         start_q == '0 && rel_q == '0));
    // R7: a host write to the end register leaves it zero when no done event came
    p_end_write_zero_r7: assert property (@(posedge clk) disable iff (rst)
        (kind == WK_END && voice_done == '0) |=> (g_q.endf == '0));
endmodule

// File: rtl/voice_key_regs.sv
module voice_key_regs
    import voice_key_pkg::*;
(
    input  logic          clk,
    input  logic          rst,
    input  logic          idx_we,
    input  logic          data_we,
    input  logic [7:0]    wdata,
    input  logic [7:0]    voice_done,
    output logic [7:0]    rdata,
    output logic [7:0]    voice_start,
    output logic [7:0]    voice_release,
    output logic [7:0]    noise_sel
);
    logic [AW-1:0] idx_q;
    logic          wr_en;
    wr_kind_t      kind;
    glob_regs_t    g_q;
    logic [DW-1:0] rf_byte;

    assign wr_en = data_we & ~idx_we;
    assign kind  = classify_write(wr_en, idx_q);

    vk_index_reg #(.AW(AW)) u_index (
        .clk   (clk),
        .rst   (rst),
        .load  (idx_we),
        .idx_in(wdata[AW-1:0]),
        .idx_q (idx_q)
    );

    vk_regfile #(
        .NREG      (NREG),
        .DW        (DW),
        .AW        (AW),
        .NOISE_ADDR(ADDR_NOISE)
    ) u_regfile (
        .clk       (clk),
        .rst       (rst),
        .we        (wr_en),
        .waddr     (idx_q),
        .wbyte     (wdata),
        .raddr     (idx_q),
        .rbyte     (rf_byte),
        .noise_byte(noise_sel)
    );

    vk_key_ctrl #(.NV(NVOICE)) u_keys (
        .clk       (clk),
        .rst       (rst),
        .kind      (kind),
        .wbyte     (wdata),
        .voice_done(voice_done),
        .g_q       (g_q),
        .start_q   (voice_start),
        .rel_q     (voice_release)
    );

    always_comb begin
        unique case (idx_q)
            ADDR_KEYON:  rdata = g_q.keyon;
            ADDR_KEYOFF: rdata = g_q.keyoff;
            ADDR_FLAGS:  rdata = g_q.flags;
            ADDR_END:    rdata = g_q.endf;
            default:     rdata = rf_byte;
        endcase
    end

    // R2: a plain register reads back the byte just written to it
    p_plain_readback_r2: assert property (@(posedge clk) disable iff (rst)
        (kind == WK_OTHER) |=> (rdata == $past(wdata)));
endmodule

// File: tb/voice_key_regs_bench.sv
module voice_key_regs_bench;
    localparam int CLK_PERIOD = 10;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       idx_we = 1'b0, data_we = 1'b0;
    logic [7:0] wdata = '0, voice_done = '0;
    logic [7:0] rdata, voice_start, voice_release, noise_sel;

    int total = 0, bad = 0;
    bit finished = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    voice_key_regs u_voice_key_regs (
        .clk(clk), .rst(rst), .idx_we(idx_we), .data_we(data_we), .wdata(wdata),
        .voice_done(voice_done), .rdata(rdata), .voice_start(voice_start),
        .voice_release(voice_release), .noise_sel(noise_sel)
    );

    // behavioural reference model
    byte unsigned m_mem [128];
    int  m_idx;
    bit  m_keyed [8];
    bit  m_pend  [8];
    int  m_start, m_rel;

    always @(posedge clk) begin
        if (rst) begin
            foreach (m_mem[k]) m_mem[k] = 0;
            m_mem[8'h6C] = 8'h60;
            m_idx = 0;
            foreach (m_keyed[k]) begin m_keyed[k] = 0; m_pend[k] = 0; end
            m_start = 0; m_rel = 0;
        end else begin
            m_start = 0; m_rel = 0;
            if (idx_we) m_idx = wdata % 128;
            else if (data_we) begin
                if (m_idx == 8'h6C && wdata >= 128) begin
                    m_mem[8'h6C] = 8'h60 + (wdata % 32);
                    m_mem[8'h4C] = 0; m_mem[8'h5C] = 0; m_mem[8'h7C] = 0;
                    foreach (m_keyed[k]) begin m_keyed[k] = 0; m_pend[k] = 0; end
                end else if (m_idx == 8'h7C) m_mem[m_idx] = 0;
                else if (m_idx == 8'h4C) begin
                    for (int v = 0; v < 8; v++)
                        if (wdata[v]) begin
                            if (m_mem[8'h5C][v] == 0) begin
                                m_start += (1 << v); m_keyed[v] = 1; m_pend[v] = 0;
                                m_mem[8'h7C][v] = 0;
                            end else m_pend[v] = 1;
                        end
                    m_mem[m_idx] = wdata;
                end else if (m_idx == 8'h5C) begin
                    for (int v = 0; v < 8; v++)
                        if (wdata[v] && m_keyed[v]) begin
                            m_rel += (1 << v); m_keyed[v] = 0; m_pend[v] = 0;
                            m_mem[8'h4C][v] = 0;
                        end else if (!wdata[v] && m_pend[v]) begin
                            m_start += (1 << v); m_keyed[v] = 1; m_pend[v] = 0;
                            m_mem[8'h7C][v] = 0;
                        end
                    m_mem[m_idx] = wdata;
                end else m_mem[m_idx] = wdata;
            end
            m_mem[8'h7C] = m_mem[8'h7C] | voice_done;
        end
    end

    task automatic chk(input string req, input string what, input int act, input int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s %s: actual=%02h expected=%02h", req, what, act, exp);
        end
    endtask

    // continuous comparison against the model, away from the active edge
    always @(negedge clk) begin
        if (!rst && !finished) begin
            chk("R2", "rdata vs model", rdata, m_mem[m_idx]);
            chk("R12", "start vs model", voice_start, m_start);
            chk("R12", "release vs model", voice_release, m_rel);
            chk("R10", "noise vs model", noise_sel, m_mem[8'h3D]);
        end
    end

    task automatic set_idx(input logic [7:0] a);
        @(negedge clk); idx_we = 1'b1; wdata = a;
        @(negedge clk); idx_we = 1'b0;
    endtask

    task automatic put(input logic [7:0] b);
        @(negedge clk); data_we = 1'b1; wdata = b;
        @(negedge clk); data_we = 1'b0;
    endtask

    task automatic done_burst(input logic [7:0] d);
        @(negedge clk); voice_done = d;
        @(negedge clk); voice_done = '0;
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            bad++; total++;
            $display("FAIL watchdog: actual=hung expected=done");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        // R1 reset state
        set_idx(8'h6C); chk("R1", "flags reset", rdata, 8'h60);
        chk("R1", "no start", voice_start, 0);
        chk("R1", "no noise", noise_sel, 0);
        set_idx(8'h4C); chk("R1", "keyon reset", rdata, 0);
        // R2 plain storage and index masking
        set_idx(8'h12); put(8'hA5); chk("R2", "plain write", rdata, 8'hA5);
        set_idx(8'h92); chk("R2", "index bit7 ignored", rdata, 8'hA5);
        // R7 end register
        done_burst(8'hFF);
        set_idx(8'h7C); chk("R7", "done sets end", rdata, 8'hFF);
        put(8'h33); chk("R7", "end write stores zero", rdata, 8'h00);
        // R3 immediate key-on
        done_burst(8'hFF);
        set_idx(8'h4C); put(8'h05); chk("R3", "start pulse", voice_start, 8'h05);
        set_idx(8'h7C); chk("R12", "pulse gone", voice_start, 0);
        chk("R3", "end cleared", rdata, 8'hFA);
        // R5 release
        set_idx(8'h5C); put(8'h04); chk("R5", "release pulse", voice_release, 8'h04);
        set_idx(8'h4C); chk("R5", "keyon bit cleared", rdata, 8'h01);
        // R4 deferred key-on while key-off bit 2 held
        put(8'h84); chk("R4", "only unheld voice starts", voice_start, 8'h80);
        // R6 pending voice starts when key-off drops
        done_burst(8'hFF);
        set_idx(8'h5C); put(8'h00); chk("R6", "pending start", voice_start, 8'h04);
        chk("R6", "no release", voice_release, 0);
        set_idx(8'h7C); chk("R6", "end cleared", rdata, 8'hFB);
        set_idx(8'h5C); put(8'h20); chk("R5", "unkeyed voice no release", voice_release, 0);
        chk("R11", "keyoff readback", rdata, 8'h20);
        set_idx(8'h4C); chk("R11", "keyon readback", rdata, 8'h84);
        // R8 soft reset
        set_idx(8'h6C); put(8'h9F); chk("R8", "flags soft reset", rdata, 8'h7F);
        set_idx(8'h4C); chk("R8", "keyon cleared", rdata, 0);
        set_idx(8'h5C); chk("R8", "keyoff cleared", rdata, 0);
        set_idx(8'h7C); chk("R8", "end cleared", rdata, 0);
        set_idx(8'h5C); put(8'hFF); chk("R8", "keyed flags cleared", voice_release, 0);
        // R9 normal flags write
        set_idx(8'h6C); put(8'h1A); chk("R9", "flags stored", rdata, 8'h1A);
        // R10 noise select
        set_idx(8'h3D); put(8'h81); chk("R10", "noise bits", noise_sel, 8'h81);
        put(8'h7E); chk("R10", "noise bits 2", noise_sel, 8'h7E);
        // random traffic, compared against the model every cycle
        for (int n = 0; n < 600; n++) begin
            int pick;
            logic [7:0] a;
            pick = $urandom_range(0, 9);
            case (pick)
                0, 1:    a = 8'h4C;
                2, 3:    a = 8'h5C;
                4:       a = 8'h6C;
                5:       a = 8'h7C;
                6:       a = 8'h3D;
                default: a = 8'($urandom_range(0, 255));
            endcase
            set_idx(a);
            @(negedge clk);
            data_we = 1'b1;
            wdata = (a == 8'h6C && $urandom_range(0, 3) != 0) ? 8'($urandom_range(0, 127))
                                                              : 8'($urandom_range(0, 255));
            voice_done = ($urandom_range(0, 3) == 0) ? 8'($urandom_range(0, 255)) : 8'h00;
            @(negedge clk);
            data_we = 1'b0; voice_done = '0;
        end
        finished = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule